// File: doc/BRIEF.md
# Spread-Spectrum Fractional Divider Word Generator

This block produces, once per reference clock cycle, the feedback-divider word of a fractional-N synthesizer. The word joins an 8-bit integer part with an 18-bit fractional part. Software programs the nominal word, the sweep timing and the sweep depth through a small write port.

With spreading switched off, the programmed word appears on the output unchanged. With spreading switched on, the block adds a triangular offset to the nominal word. A prescaler turns reference cycles into step instants. A half-period counter flips the sweep direction each time it completes a half-period. In down mode the offset moves from zero to minus the full span and back. In center mode it swings symmetrically about the nominal word, starting at zero and heading down. Any write restarts the sweep from zero, so new settings take effect from a known phase.

The noise shaper that consumes the word, the oscillator and lock detection sit outside this block.

Top module: `ssc_frac_mod`

## Requirements
- R1: After reset the output word is 0, all fields are 0 except the adjust field, and spreading is off.
- R2: The output word is {integer[7:0], fraction[17:0]}. The fraction is written in three pieces: field 1 sets bits 7:0 from data[7:0], field 2 sets bits 15:8 from data[7:0], and field 3 sets bits 17:16 from data[1:0]. Field 0 sets the integer from data[7:0]. Field 4 is the half-period, field 5 the step, field 6 the adjust period and field 7 the control.
- R3: While spreading is off, the output equals the nominal word and does not change between writes.
- R4: With spreading on, the offset changes only once every adjust+1 reference cycles, and only by exactly one step.
- R5: In down mode, with half-period+1 = N·(adjust+1), the offset after s steps follows 0, −step, …, −N·step and back to 0, with period 2N steps.
- R6: In center mode, with N even, the offset starts at 0, first moves down to −(N/2)·step, then swings between −(N/2)·step and +(N/2)·step.
- R7: When a step and a direction reversal fall in the same cycle, the step uses the old direction and the reversal applies from the next step.
- R8: Any write clears the offset and restarts the prescaler and half-period counter. The output equals the new nominal word right after the write edge.
- R9: Control field bit 1 enables spreading and bit 0 selects center (1) or down (0) mode. Center selected without enable produces no sweep.
- R10: The adjust period resets to 2.
- R11: The output is computed modulo 2^26, so a downward offset from a zero nominal wraps to the top of the range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field select (0..7) |
| wr_data | input | 16 | Field write data |
| div_word | output | 26 | Instantaneous divider word |

## Verification
The hardest cycle is the one in which the prescaler issues a step while the half-period counter reaches its limit, so that a step and a reversal coincide. The bench chooses half-periods whose length is a multiple of the adjust period, which makes every reversal land on a step cycle, and compares each cycle's output against a closed-form triangle computed from the step count. A second collision comes from a write arriving mid-sweep, on or near a step instant. That case is judged by requiring the nominal word on the next sample, followed by a fresh profile.

// File: rtl/ssc_frac_pkg.sv
// Shared definitions for the spread-spectrum divider word generator.
// Assumes a 3-bit field select; field numbering is fixed here.
package ssc_frac_pkg;
    typedef enum logic [2:0] {
        FLD_INT     = 3'd0,
        FLD_FRAC_LO = 3'd1,
        FLD_FRAC_MD = 3'd2,
        FLD_FRAC_HI = 3'd3,
        FLD_PERIOD  = 3'd4,
        FLD_STEP    = 3'd5,
        FLD_ADJ     = 3'd6,
        FLD_CTRL    = 3'd7
    } fld_e;

    localparam int CTRL_CENTER_BIT = 0;
    localparam int CTRL_ENABLE_BIT = 1;
endpackage

// File: rtl/ssc_cfg_regs.sv
// Field storage for the generator. Holds the nominal word, the sweep timing
// and the control bits. Exposes both the stored values and the values they
// take at the next edge, so that a restart can use freshly written settings.
// Assumes FRAC_W lies between 17 and 24 and INT_W <= CNT_W.
module ssc_cfg_regs
    import ssc_frac_pkg::*;
#(
    parameter int INT_W   = 8,
    parameter int FRAC_W  = 18,
    parameter int CNT_W   = 16,
    parameter int ADJ_RST = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    output logic [INT_W-1:0]   int_q,
    output logic [FRAC_W-1:0]  frac_q,
    output logic [CNT_W-1:0]   period_q,
    output logic [CNT_W-1:0]   step_q,
    output logic [CNT_W-1:0]   adj_q,
    output logic               en_q,
    output logic               center_q,
    output logic [CNT_W-1:0]   period_d,
    output logic               en_d,
    output logic               center_d
);
    localparam int HI_W = FRAC_W - 16;

    logic [INT_W-1:0]  int_d;
    logic [FRAC_W-1:0] frac_d;
    logic [CNT_W-1:0]  step_d;
    logic [CNT_W-1:0]  adj_d;

    // Next-state decode of a field write.
    always_comb begin
        int_d    = int_q;
        frac_d   = frac_q;
        period_d = period_q;
        step_d   = step_q;
        adj_d    = adj_q;
        en_d     = en_q;
        center_d = center_q;
        if (wr_en) begin
            case (fld_e'(wr_addr))
                FLD_INT:     int_d            = wr_data[INT_W-1:0];
                FLD_FRAC_LO: frac_d[7:0]      = wr_data[7:0];
                FLD_FRAC_MD: frac_d[15:8]     = wr_data[7:0];
                FLD_FRAC_HI: frac_d[FRAC_W-1:16] = wr_data[HI_W-1:0];
                FLD_PERIOD:  period_d         = wr_data;
                FLD_STEP:    step_d           = wr_data;
                FLD_ADJ:     adj_d            = wr_data;
                FLD_CTRL: begin
                    en_d     = wr_data[CTRL_ENABLE_BIT];
                    center_d = wr_data[CTRL_CENTER_BIT];
                end
                default: ;
            endcase
        end
    end

    // Field registers with reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q    <= '0;
            frac_q   <= '0;
            period_q <= '0;
            step_q   <= '0;
            adj_q    <= CNT_W'(ADJ_RST);
            en_q     <= 1'b0;
            center_q <= 1'b0;
        end else begin
            int_q    <= int_d;
            frac_q   <= frac_d;
            period_q <= period_d;
            step_q   <= step_d;
            adj_q    <= adj_d;
            en_q     <= en_d;
            center_q <= center_d;
        end
    end
endmodule

// File: rtl/ssc_phase_gen.sv
// Sweep timing: a prescaler that marks a step instant every adj+1 cycles and
// a half-period counter that reverses the sweep direction each time it
// reaches the programmed half-period. On restart the prescaler clears, the
// direction points down, and the half-period counter starts at 0 (down mode)
// or at half its range (center mode), so that center sweeps begin mid-slope.
module ssc_phase_gen #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] adj_q,
    input  logic [CNT_W-1:0] period_q,
    input  logic [CNT_W-1:0] period_d,
    input  logic             center_d,
    input  logic             en_d,
    output logic             tick,
    output logic             turn,
    output logic             dir_up
);
    logic [CNT_W-1:0] pre_q;
    logic [CNT_W-1:0] hc_q;
    logic [CNT_W:0]   len_d;
    logic [CNT_W-1:0] hc_init;

    // Step instant and reversal instant.
    always_comb begin
        tick = (pre_q == adj_q);
        turn = (hc_q == period_q);
    end

    // Start point of the half-period counter for the settings being applied.
    always_comb begin
        len_d   = {1'b0, period_d} + 1'b1;
        hc_init = (center_d && en_d) ? len_d[CNT_W:1] : '0;
    end

    // Prescaler, half-period counter and direction flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            hc_q   <= '0;
            dir_up <= 1'b0;
        end else if (restart) begin
            pre_q  <= '0;
            hc_q   <= hc_init;
            dir_up <= 1'b0;
        end else begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            hc_q  <= turn ? '0 : hc_q + 1'b1;
            if (turn) begin
                dir_up <= ~dir_up;
            end
        end
    end
endmodule

// File: rtl/ssc_offset_acc.sv
// Offset accumulator: adds or subtracts one step on each step instant,
// in the direction held before any reversal of the same cycle. Cleared on
// restart. Arithmetic is modulo 2^WORD_W, matching the output word.
module ssc_offset_acc #(
    parameter int WORD_W = 26,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              tick,
    input  logic              dir_up,
    input  logic [CNT_W-1:0]  step_q,
    output logic [WORD_W-1:0] offset_q
);
    logic [WORD_W-1:0] step_x;

    // Step widened to the word width.
    always_comb begin
        step_x = WORD_W'(step_q);
    end

    // Offset register.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            offset_q <= '0;
        end else if (tick) begin
            offset_q <= dir_up ? offset_q + step_x : offset_q - step_x;
        end
    end
endmodule

// File: rtl/ssc_frac_mod.sv
// Top of the spread-spectrum divider word generator. Combines the field
// registers, sweep timing and offset accumulator; the output is the nominal
// word plus the current offset, modulo 2^WORD_W. Spreading off, or any write,
// counts as a restart of the sweep.
module ssc_frac_mod #(
    parameter int INT_W   = 8,
    parameter int FRAC_W  = 18,
    parameter int CNT_W   = 16,
    parameter int ADJ_RST = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [2:0]               wr_addr,
    input  logic [CNT_W-1:0]         wr_data,
    output logic [INT_W+FRAC_W-1:0]  div_word
);
    localparam int WORD_W = INT_W + FRAC_W;

    logic [INT_W-1:0]  int_q;
    logic [FRAC_W-1:0] frac_q;
    logic [CNT_W-1:0]  period_q, step_q, adj_q, period_d;
    logic              en_q, center_q, en_d, center_d;
    logic              restart, tick, turn, dir_up;
    logic [WORD_W-1:0] nominal, offset_q;

    ssc_cfg_regs #(
        .INT_W(INT_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W), .ADJ_RST(ADJ_RST)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .int_q(int_q), .frac_q(frac_q),
        .period_q(period_q), .step_q(step_q), .adj_q(adj_q),
        .en_q(en_q), .center_q(center_q), .period_d(period_d),
        .en_d(en_d), .center_d(center_d)
    );

    // Sweep restarts on any write and is held at its start while disabled.
    always_comb begin
        restart = wr_en || !en_q;
    end

    ssc_phase_gen #(.CNT_W(CNT_W)) phase_i (
        .clk(clk), .rst_n(rst_n), .restart(restart), .adj_q(adj_q),
        .period_q(period_q), .period_d(period_d), .center_d(center_d),
        .en_d(en_d), .tick(tick), .turn(turn), .dir_up(dir_up)
    );

    ssc_offset_acc #(.WORD_W(WORD_W), .CNT_W(CNT_W)) acc_i (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
        .dir_up(dir_up), .step_q(step_q), .offset_q(offset_q)
    );

    // Output word: nominal plus offset.
    always_comb begin
        nominal  = {int_q, frac_q};
        div_word = nominal + offset_q;
    end

    logic unused_center;
    assign unused_center = center_q;
endmodule

// File: rtl/ssc_frac_mod_chk.sv
// Property checker for the divider word generator, bound to its top.
// Observes field state, sweep timing and the offset across submodules.
module ssc_frac_mod_chk #(
    parameter int WORD_W = 26,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              en_q,
    input logic              tick,
    input logic              turn,
    input logic              dir_up,
    input logic [CNT_W-1:0]  step_q,
    input logic [WORD_W-1:0] nominal,
    input logic [WORD_W-1:0] offset_q,
    input logic [WORD_W-1:0] div_word
);
    AST_OFF_IS_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> div_word == nominal); // R3

    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (offset_q == '0) && (div_word == nominal)); // R8

    AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !wr_en && !tick) |=> $stable(offset_q)); // R4

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !wr_en && tick) |=>
        ((offset_q - $past(offset_q)) == WORD_W'($past(step_q))) ||
        (($past(offset_q) - offset_q) == WORD_W'($past(step_q)))); // R4

    AST_TURN_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !wr_en && turn) |=> dir_up != $past(dir_up)); // R7

    AST_START_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !dir_up); // R6
endmodule

bind ssc_frac_mod ssc_frac_mod_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .en_q(en_q), .tick(tick),
    .turn(turn), .dir_up(dir_up), .step_q(step_q), .nominal(nominal),
    .offset_q(offset_q), .div_word(div_word)
);

// File: tb/ssc_frac_mod_tb_top.sv
module ssc_frac_mod_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [25:0] div_word;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ssc_frac_mod dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .div_word(div_word)
    );

    task automatic check(string req, logic [25:0] act, logic [25:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One write; returns at the negedge just after the write edge.
    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic longint tri_off(longint s, longint n, longint step);
        longint p = s % (2 * n);
        longint m = (p <= n) ? p : 2 * n - p;
        return -m * step;
    endfunction

    function automatic logic [25:0] model(longint nom, longint step, longint adj,
                                          longint n, bit center, longint t);
        longint s = t / (adj + 1);
        longint off;
        if (center) off = tri_off(s + n / 2, n, step) + (n / 2) * step;
        else        off = tri_off(s, n, step);
        return 26'(nom + off);
    endfunction

    // Compares the output with the closed-form triangle from t = 0.
    task automatic profile(string req, longint nom, longint step, longint adj,
                           longint n, bit center, int cycles);
        for (int t = 0; t < cycles; t++) begin
            check(req, div_word, model(nom, step, adj, n, center, t));
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R1", div_word, 26'd0);
    endtask

    // Default adjust period of 2: down sweep with N=2.
    task automatic t_default_adj();
        wr(3'd0, 16'h0040);
        wr(3'd5, 16'd10);
        wr(3'd4, 16'd5);
        wr(3'd7, 16'h0002);
        profile("R10", 64'h40 << 18, 10, 2, 2, 1'b0, 13);
        wr(3'd7, 16'h0002);
        repeat (6) @(negedge clk);
        check("R5", div_word, 26'((64'h40 << 18) - 20));
        repeat (6) @(negedge clk);
        check("R7", div_word, 26'(64'h40 << 18));
    endtask

    // Field assembly, masking of the top fraction piece, and disabled hold.
    task automatic t_word();
        logic [25:0] exp;
        wr(3'd7, 16'h0000);
        wr(3'd0, 16'hFF5A);
        wr(3'd1, 16'hAB34);
        wr(3'd2, 16'hCD12);
        wr(3'd3, 16'hFFFF);
        exp = {8'h5A, 2'b11, 8'h12, 8'h34};
        check("R2", div_word, exp);
        wr(3'd7, 16'h0001);
        for (int i = 0; i < 20; i++) begin
            check("R9", div_word, exp);
            @(negedge clk);
        end
        wr(3'd5, 16'd9);
        for (int i = 0; i < 10; i++) begin
            check("R3", div_word, exp);
            @(negedge clk);
        end
    endtask

    task automatic t_down();
        wr(3'd0, 16'h0080);
        wr(3'd1, 16'h0000); wr(3'd2, 16'h0000); wr(3'd3, 16'h0000);
        wr(3'd6, 16'd2);
        wr(3'd4, 16'd8);     // N = 3
        wr(3'd5, 16'd100);
        wr(3'd7, 16'h0002);
        profile("R5", 64'h80 << 18, 100, 2, 3, 1'b0, 60);
    endtask

    task automatic t_center();
        wr(3'd4, 16'd11);    // N = 4
        wr(3'd5, 16'd7);
        wr(3'd7, 16'h0003);
        profile("R6", 64'h80 << 18, 7, 2, 4, 1'b1, 80);
    endtask

    task automatic t_fast();
        wr(3'd6, 16'd0);
        wr(3'd4, 16'd3);     // N = 4
        wr(3'd5, 16'd1);
        wr(3'd7, 16'h0002);
        profile("R4", 64'h80 << 18, 1, 0, 4, 1'b0, 24);
    endtask

    // Write mid-sweep restarts from zero with the new step.
    task automatic t_restart();
        wr(3'd6, 16'd2);
        wr(3'd4, 16'd11);
        wr(3'd5, 16'd7);
        wr(3'd7, 16'h0003);
        repeat (5) @(negedge clk);
        wr(3'd5, 16'd3);
        check("R8", div_word, 26'(64'h80 << 18));
        profile("R8", 64'h80 << 18, 3, 2, 4, 1'b1, 30);
    endtask

    task automatic t_wrap();
        wr(3'd0, 16'h0000);
        wr(3'd6, 16'd0);
        wr(3'd4, 16'd1);     // N = 2
        wr(3'd5, 16'd5);
        wr(3'd7, 16'h0002);
        @(negedge clk);
        check("R11", div_word, 26'h3FFFFFB);
        wr(3'd7, 16'h0002);
        profile("R11", 0, 5, 0, 2, 1'b0, 10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_adj();
        t_word();
        t_down();
        t_center();
        t_fast();
        t_restart();
        t_wrap();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule